// File: doc/BRIEF.md
# Frequency-Directed Run-Length Stream Encoder

This block turns a serial stream of test bits into a compressed stream of variable-length codewords. Input bits arrive one per handshake. The encoder counts the zeros that come before each one. When a one arrives it closes the run, and the encoder emits the codeword for the number of zeros it counted. Code groups double in size from one group to the next. Group j holds run lengths 2^j-2 through 2^(j+1)-3. Its codeword is j-1 ones, then a zero, then a j-bit offset into the group, so every codeword is exactly 2j bits long. Six groups are supported, so the longest run that can be encoded is 125 zeros.

Patterns are fed back to back as one continuous stream, so a run may span pattern boundaries and idle cycles. Both data sides use valid/ready handshakes. An input bit is taken on a cycle where in_valid and in_ready are both high. An output bit is delivered on a cycle where out_valid and out_ready are both high. While a codeword is being sent, in_ready is low, so the input is stalled. While out_ready is low, the presented bit and last flag stay frozen. A flush input closes the stream: any pending zeros are encoded as a final run, and then done rises. A run that would grow past the largest group raises error instead, and the block stops.

Top module: `fdr_encoder`

## Requirements
- R1: A run of length 0 (a lone one) encodes as 00 and a run of length 1 encodes as 01.
- R2: Runs of 2 to 5 zeros encode as prefix 10 followed by a 2-bit offset equal to length-2 (2 gives 1000, 5 gives 1011).
- R3: Runs of 6 to 13 zeros encode as prefix 110 followed by a 3-bit offset equal to length-6 (6 gives 110000, 13 gives 110111).
- R4: For groups j = 4, 5 and 6 (lengths 14-29, 30-61 and 62-125), the codeword is j-1 ones, a zero, and a j-bit offset equal to length-(2^j-2). The codeword is 2j bits long, so 125 gives 111110111111.
- R5: Codeword bits leave the prefix first, then the offset most significant bit first, one bit per output handshake. out_last is high only with the final bit of each codeword.
- R6: The zero count carries across cycles where in_valid is low. A run is ended only by a one (or by flush).
- R7: in_ready is low whenever out_valid is high. In the cycle after the final bit's handshake, in_ready is high again.
- R8: While out_valid is high and out_ready is low, out_valid, out_bit and out_last keep their values into the next cycle.
- R9: A flush with pending zeros emits their codeword and then raises done in the cycle after the final bit's handshake. A flush with no pending zeros raises done in the next cycle and emits nothing. After done, in_ready stays low and done stays high.
- R10: Accepting a zero when 125 zeros are already pending raises error in the next cycle. Error is sticky, and after it in_ready and out_valid stay low.
- R11: After reset, in_ready is high and out_valid, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Encoder takes the offered bit this cycle |
| in_bit | input | 1 | Stream bit, a one closes the current run |
| flush | input | 1 | End of stream; wins over in_valid in the same cycle |
| out_valid | output | 1 | Codeword bit presented |
| out_ready | input | 1 | Consumer takes the presented bit |
| out_bit | output | 1 | Current codeword bit |
| out_last | output | 1 | Presented bit is the final bit of its codeword |
| done | output | 1 | Stream finished after flush |
| error | output | 1 | A run longer than the largest group was seen |

## Verification
A wrong zero count shows up as a wrong offset or a wrong group in the very next codeword after the closing one. That codeword comes out within twelve cycles. A counter that drops its value across idle cycles shows up the same way. A broken bit order or group decoder gives a wrong bit pattern, or out_last on the wrong bit, in that same codeword. A broken emit state shows up in different ways: in_ready fails to rise in the cycle after the final handshake, or the frozen bit changes under back-pressure, or done or error arrives a cycle late or early.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [1:0] {
    ST_TAKE  = 2'd0,
    ST_EMIT  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } fdr_state_e;
endpackage

// File: rtl/fdr_run_counter.sv
module fdr_run_counter #(
  parameter int unsigned LEN_W   = 7,
  parameter int unsigned MAX_LEN = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [LEN_W-1:0] count,
  output logic             at_max
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign at_max = (count == LIMIT);
endmodule

// File: rtl/fdr_code_gen.sv
module fdr_code_gen #(
  parameter int unsigned GROUPS = 6,
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned CW_W   = 12,
  parameter int unsigned NB_W   = 4
) (
  input  logic [LEN_W-1:0] run_len,
  output logic [CW_W-1:0]  cw,
  output logic [NB_W-1:0]  nbits
);
  // Adding 2 to the run length puts the value for group g in [2^g, 2^(g+1)).
  // The low g bits of that value are the offset within the group.
  logic [LEN_W:0]    biased;
  logic [GROUPS-1:0] hit;
  int                grp;

  assign biased = {1'b0, run_len} + (LEN_W+1)'(2);

  for (genvar g = 1; g <= GROUPS; g++) begin : g_hit
    localparam int LO = 1 << g;
    localparam int HI = 1 << (g + 1);
    assign hit[g-1] = (int'(biased) >= LO) && (int'(biased) < HI);
  end

  always_comb begin
    logic [LEN_W:0] sh;
    grp = 0;
    for (int g = 0; g < GROUPS; g++) begin
      if (hit[g]) grp = g + 1;
    end
    cw = '0;
    sh = '0;
    for (int i = 0; i < CW_W; i++) begin
      if (i < grp - 1) begin
        cw[CW_W-1-i] = 1'b1;
      end else if (i == grp - 1) begin
        cw[CW_W-1-i] = 1'b0;
      end else if (i < 2 * grp) begin
        sh = biased >> (2 * grp - 1 - i);
        cw[CW_W-1-i] = sh[0];
      end
    end
    nbits = NB_W'(2 * grp);
  end
endmodule

// File: rtl/fdr_serializer.sv
module fdr_serializer #(
  parameter int unsigned CW_W = 12,
  parameter int unsigned NB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CW_W-1:0] load_cw,
  input  logic [NB_W-1:0] load_nbits,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            out_bit,
  output logic            out_last,
  output logic            fin
);
  logic [CW_W-1:0] sreg;
  logic [NB_W-1:0] remain;
  logic            fire;

  assign out_valid = (remain != '0);
  assign out_bit   = sreg[CW_W-1];
  assign out_last  = (remain == NB_W'(1));
  assign fire      = out_valid && out_ready;
  assign fin       = fire && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      remain <= '0;
    end else if (load) begin
      sreg   <= load_cw;
      remain <= load_nbits;
    end else if (fire) begin
      sreg   <= sreg << 1;
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/fdr_encoder.sv
module fdr_encoder #(
  parameter int unsigned GROUPS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic flush,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last,
  output logic done,
  output logic error
);
  import fdr_pkg::*;

  localparam int unsigned MAX_LEN = (1 << (GROUPS + 1)) - 3;
  localparam int unsigned LEN_W   = GROUPS + 1;
  localparam int unsigned CW_W    = 2 * GROUPS;
  localparam int unsigned NB_W    = $clog2(CW_W + 1);

  fdr_state_e       state;
  logic             take, flush_now, load, fin, at_max, fault, final_q;
  logic             cnt_clr, cnt_inc;
  logic [LEN_W-1:0] count;
  logic [CW_W-1:0]  cw;
  logic [NB_W-1:0]  nbits;

  assign in_ready  = (state == ST_TAKE) && !flush;
  assign take      = in_valid && in_ready;
  assign flush_now = (state == ST_TAKE) && flush;
  assign fault     = take && !in_bit && at_max;
  assign load      = (take && in_bit) || (flush_now && count != '0);
  assign cnt_clr   = (take && in_bit) || flush_now;
  assign cnt_inc   = take && !in_bit && !at_max;
  assign done      = (state == ST_DONE);
  assign error     = (state == ST_FAULT);

  fdr_run_counter #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .count(count), .at_max(at_max)
  );

  fdr_code_gen #(.GROUPS(GROUPS), .LEN_W(LEN_W), .CW_W(CW_W), .NB_W(NB_W)) u_gen (
    .run_len(count), .cw(cw), .nbits(nbits)
  );

  fdr_serializer #(.CW_W(CW_W), .NB_W(NB_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .load_cw(cw), .load_nbits(nbits),
    .out_ready(out_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_last(out_last), .fin(fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_TAKE;
      final_q <= 1'b0;
    end else begin
      case (state)
        ST_TAKE: begin
          if (fault) begin
            state <= ST_FAULT;
          end else if (load) begin
            state   <= ST_EMIT;
            final_q <= flush_now;
          end else if (flush_now) begin
            state <= ST_DONE;
          end
        end
        ST_EMIT: begin
          if (fin) state <= final_q ? ST_DONE : ST_TAKE;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/fdr_encoder_chk.sv
module fdr_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_bit,
  input logic flush,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last,
  input logic done,
  input logic error
);
  a_r7_stall_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r8_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

  a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r9_done_sticky_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !in_ready && !out_valid));

  a_r10_error_sticky_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !in_ready && !out_valid));

  a_r10_error_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(error && done));
endmodule

bind fdr_encoder fdr_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bit(in_bit), .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
  .out_bit(out_bit), .out_last(out_last), .done(done), .error(error)
);

// File: tb/fdr_encoder_tb.sv
`timescale 1ns/1ps
module fdr_encoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, flush = 1'b0;
  logic out_ready;
  logic in_ready, out_valid, out_bit, out_last, done, error;
  logic bp = 1'b0;
  logic [7:0] lfsr = 8'h5b;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic q_bit[$];
  logic q_last[$];
  logic prev_stall = 1'b0, prev_bit = 1'b0;

  always #4 clk = ~clk;

  fdr_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_last(out_last), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_bit == prev_bit, "R8 hold", int'(out_bit), int'(prev_bit));
      if (out_valid)
        chk(!in_ready, "R7 stall", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        q_bit.push_back(out_bit);
        q_last.push_back(out_last);
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    q_bit.delete(); q_last.delete();
  endtask

  task automatic send_bit(input logic b);
    in_valid = 1'b1; in_bit = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_code(input int len, output int code, output int nb);
    int j = 0;
    for (int g = 1; g <= 6; g++)
      if (len >= (1 << g) - 2 && len <= (1 << (g + 1)) - 3) j = g;
    code = 0;
    for (int i = 0; i < j - 1; i++) code = (code << 1) | 1;
    code = code << 1;
    code = (code << j) | (len - ((1 << j) - 2));
    nb = 2 * j;
  endtask

  // Waits for nb output bits, then compares bits and last flags.
  // Ends 2 ns after the edge of the final handshake.
  task automatic collect_check(input int len, input string req);
    int code, nb, act, t;
    bit last_ok;
    expect_code(len, code, nb);
    t = 0;
    while (q_bit.size() < nb && t < 400) begin
      @(posedge clk); #2;
      t++;
    end
    act = 0;
    last_ok = (q_bit.size() == nb);
    foreach (q_bit[i]) begin
      act = (act << 1) | int'(q_bit[i]);
      if (q_last[i] != (i == nb - 1)) last_ok = 1'b0;
    end
    chk(act == code && q_bit.size() == nb, req, act, code);
    chk(last_ok, "R5 last flag", q_bit.size(), nb);
    q_bit.delete(); q_last.delete();
  endtask

  task automatic run_len(input int len, input string req);
    send_zeros(len);
    send_bit(1'b1);
    collect_check(len, req);
    chk(in_ready, "R7 ready after last", int'(in_ready), 1);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(in_ready && !out_valid && !done && !error, "R11 reset",
        {in_ready, out_valid, done, error}, 4'b1000);
  endtask

  task automatic t_small();
    do_reset();
    run_len(0, "R1 len0");
    run_len(1, "R1 len1");
    run_len(2, "R2 len2");
    run_len(5, "R2 len5");
    run_len(3, "R2 len3");
    run_len(6, "R3 len6");
    run_len(13, "R3 len13");
  endtask

  task automatic t_large();
    do_reset();
    run_len(14, "R4 len14");
    run_len(29, "R4 len29");
    run_len(30, "R4 len30");
    run_len(61, "R4 len61");
    run_len(62, "R4 len62");
    run_len(125, "R4 len125");
  endtask

  task automatic t_gap();
    do_reset();
    send_zeros(3);
    idle(5);
    send_zeros(4);
    idle(3);
    send_bit(1'b1);
    collect_check(7, "R6 run across gap");
  endtask

  task automatic t_backpressure();
    do_reset();
    bp = 1'b1;
    run_len(20, "R8 len20 backpressure");
    run_len(2, "R8 len2 backpressure");
    run_len(100, "R8 len100 backpressure");
    bp = 1'b0;
    idle(2);
  endtask

  task automatic t_flush_pending();
    do_reset();
    send_zeros(9);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    chk(!done, "R9 done not early", int'(done), 0);
    collect_check(9, "R9 flush codeword");
    chk(done && !out_valid, "R9 done after last", int'(done), 1);
    idle(4);
    chk(done && !in_ready && q_bit.size() == 0, "R9 done sticky", int'(in_ready), 0);
  endtask

  task automatic t_flush_empty();
    do_reset();
    run_len(0, "R1 len0 before flush");
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    chk(done, "R9 empty flush done", int'(done), 1);
    idle(5);
    chk(q_bit.size() == 0 && done, "R9 empty flush silent", q_bit.size(), 0);
  endtask

  task automatic t_error();
    do_reset();
    send_zeros(125);
    chk(!error, "R10 no error at 125", int'(error), 0);
    in_valid = 1'b1; in_bit = 1'b0;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(error, "R10 error raised", int'(error), 1);
    idle(5);
    chk(error && !in_ready && !out_valid && q_bit.size() == 0, "R10 error stop",
        {error, in_ready, out_valid}, 3'b100);
  endtask

  initial begin
    out_ready = 1'b1;
    t_reset();
    t_small();
    t_large();
    t_gap();
    t_backpressure();
    t_flush_pending();
    t_flush_empty();
    t_error();
    report();
  end
endmodule